// File: doc/BRIEF.md
# Instruction Cache Maintenance Control Unit

This block is the software-facing control and status unit of an instruction cache. It sits on a simple 32-bit register bus and holds the cache enable and the associativity mode. Software can request a full invalidate, and the unit then walks every tag line of the cache, one per clock, driving a clear strobe and a line index to the tag array. It reports whether a sweep is running and whether one has finished, and it latches an error event signalled by the cache datapath. One interrupt line combines the finished and error events, each behind its own enable.

Two monitor counters count hit and miss strobes coming from the cache lookup logic. Each has its own enable and its own one-shot reset bit in the control word. The tag and data arrays, the lookup itself and any address remapping live outside this unit.

Register accesses use a one-cycle write strobe with address and data. Read data is combinational from the address. Register offsets are byte offsets: control 0x00, status 0x04, interrupt enable 0x08, flag clear 0x0C, hit count 0x10, miss count 0x14.

Top module: `icm_ctrl_unit`

## Requirements
- R1: After reset the control word reads 0x0000_0004, with only the associativity bit set. Status, interrupt enable and both counters read 0, and `irq` and `tag_clr_en` are low.
- R2: A control write stores the cache enable from bit 0 and the hit and miss monitor enables from bits 16 and 17. The associativity bit 2 (0 = direct-mapped, 1 = set-associative) takes the written value only when the enable held before the write is 0.
- R3: Writing 1 to control bit 1 sets the invalidate request, which reads back as 1. The sweep starts on the next clock, and the request bit clears on the clock after the busy flag is seen set. Writing 0 to bit 1 starts nothing.
- R4: A sweep drives `tag_clr_en` high for exactly LINES consecutive cycles, with `tag_clr_idx` stepping 0, 1, … LINES-1. Status bit 0 (busy) is high in exactly those cycles.
- R5: Status bit 1 (finished) sets in the cycle busy falls. Status bit 2 (error) sets whenever `err_stb` is high at a clock edge.
- R6: A write to the clear register at 0x0C with bit 1 set clears the finished flag, and with bit 2 set clears the error flag. That register reads as 0.
- R7: `irq` is high exactly when (finished AND interrupt enable bit 1) OR (error AND interrupt enable bit 2).
- R8: The hit counter at 0x10 is 32 bits wide and counts one per clock with `hit_stb` high while control bit 16 is set. It holds its value otherwise.
- R9: The miss counter at 0x14 is 16 bits wide in bits 15:0, with bits 31:16 reading 0. It counts `miss_stb` while control bit 17 is set.
- R10: Writing 1 to control bit 18 (hit) or bit 19 (miss) makes that counter read 0 in the next cycle. Bits 18 and 19 always read 0.
- R11: Writes to the status, hit and miss offsets change no state.
- R12: Each counter stops at all-ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hit_stb | input | 1 | One lookup hit this cycle |
| miss_stb | input | 1 | One lookup miss this cycle |
| err_stb | input | 1 | Cache error event this cycle |
| cache_en | output | 1 | Cache enable |
| assoc_mode | output | 1 | 1 = set-associative, 0 = direct-mapped |
| tag_clr_en | output | 1 | Clear the valid bit of line `tag_clr_idx` |
| tag_clr_idx | output | $clog2(LINES) | Tag line being cleared |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the rules that need no history beyond one cycle. These are: the request bit dropping after busy is seen, the associativity bit staying frozen while enabled, the sweep index stepping by one within range, the finished flag appearing as busy falls, and each counter saturating, holding when idle and clearing after a reset request. Only the bench scenarios can show end-to-end results. Those are the exact sweep length and index order as seen from the bus, the register read values and ignored writes, the interrupt combinations, counts that match a model under random strobe and enable patterns, and miss-counter saturation after more than 65535 strobes.

// File: rtl/icm_pkg.sv
package icm_pkg;
   localparam logic [7:0] OFS_CTRL  = 8'h00;
   localparam logic [7:0] OFS_STAT  = 8'h04;
   localparam logic [7:0] OFS_IEN   = 8'h08;
   localparam logic [7:0] OFS_FCLR  = 8'h0C;
   localparam logic [7:0] OFS_HITS  = 8'h10;
   localparam logic [7:0] OFS_MISS  = 8'h14;

   localparam int B_EN     = 0;
   localparam int B_INV    = 1;
   localparam int B_ASSOC  = 2;
   localparam int B_HMEN   = 16;
   localparam int B_MMEN   = 17;
   localparam int B_HMRST  = 18;
   localparam int B_MMRST  = 19;

   localparam int B_BUSY   = 0;
   localparam int B_DONE   = 1;
   localparam int B_ERR    = 2;
endpackage

// File: rtl/icm_sweep.sv
module icm_sweep #(
   parameter int LINES = 64,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

   generate
      if (LINES < 2) begin : g_bad_lines
         $error("icm_sweep: LINES must be at least 2");
      end
   endgenerate

   assign done = busy && (idx == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (busy) begin
         if (idx == LAST) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end
   end

   // R4: index stays inside the line range during the sweep
   assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx <= LAST));
   // R4: one line per clock, no gaps
   assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/icm_satcnt.sv
module icm_satcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;

   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("icm_satcnt: W must be 1..32");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (clr)                cnt <= '0;
      else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
   end

   // R12: all-ones is sticky until cleared
   assert_hold_at_top_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP && !clr) |=> (cnt == TOP));
   // R10: a reset request zeroes the count one cycle later
   assert_clear_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R8: no strobe, no change
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/icm_ctrl_unit.sv
module icm_ctrl_unit
   import icm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LINES  = 64,
   parameter int HIT_W  = 32,
   parameter int MISS_W = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              hit_stb,
   input  logic              miss_stb,
   input  logic              err_stb,
   output logic              cache_en,
   output logic              assoc_mode,
   output logic              tag_clr_en,
   output logic [IDX_W-1:0]  tag_clr_idx,
   output logic              irq
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("icm_ctrl_unit: ADDR_W must reach offset 0x14");
      end
      if (HIT_W > 32 || MISS_W > 32) begin : g_bad_cnt
         $error("icm_ctrl_unit: counters must fit a 32-bit word");
      end
   endgenerate

   logic wr_ctrl, wr_ien, wr_fclr;
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
   assign wr_fclr = bus_wr && (bus_addr == ADDR_W'(OFS_FCLR));

   logic en_q, inv_q, assoc_q, hmen_q, mmen_q;
   logic ie_done_q, ie_err_q, done_q, err_q;
   logic busy, sweep_end;
   logic [HIT_W-1:0]  hit_cnt;
   logic [MISS_W-1:0] miss_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         assoc_q <= 1'b1;
         hmen_q  <= 1'b0;
         mmen_q  <= 1'b0;
      end else if (wr_ctrl) begin
         en_q   <= bus_wdata[B_EN];
         hmen_q <= bus_wdata[B_HMEN];
         mmen_q <= bus_wdata[B_MMEN];
         if (!en_q) assoc_q <= bus_wdata[B_ASSOC];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              inv_q <= 1'b0;
      else if (busy)                           inv_q <= 1'b0;
      else if (wr_ctrl && bus_wdata[B_INV])    inv_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_done_q <= 1'b0;
         ie_err_q  <= 1'b0;
      end else if (wr_ien) begin
         ie_done_q <= bus_wdata[B_DONE];
         ie_err_q  <= bus_wdata[B_ERR];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (sweep_end)                          done_q <= 1'b1;
         else if (wr_fclr && bus_wdata[B_DONE])  done_q <= 1'b0;
         if (err_stb)                            err_q  <= 1'b1;
         else if (wr_fclr && bus_wdata[B_ERR])   err_q  <= 1'b0;
      end
   end

   icm_sweep #(.LINES(LINES)) u_sweep (
      .clk   (clk),
      .rst_n (rst_n),
      .start (inv_q && !busy),
      .busy  (busy),
      .done  (sweep_end),
      .idx   (tag_clr_idx)
   );

   icm_satcnt #(.W(HIT_W)) u_hits (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_ctrl && bus_wdata[B_HMRST]),
      .inc   (hit_stb && hmen_q),
      .cnt   (hit_cnt)
   );

   icm_satcnt #(.W(MISS_W)) u_miss (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_ctrl && bus_wdata[B_MMRST]),
      .inc   (miss_stb && mmen_q),
      .cnt   (miss_cnt)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_CTRL): begin
            bus_rdata[B_EN]    = en_q;
            bus_rdata[B_INV]   = inv_q;
            bus_rdata[B_ASSOC] = assoc_q;
            bus_rdata[B_HMEN]  = hmen_q;
            bus_rdata[B_MMEN]  = mmen_q;
         end
         ADDR_W'(OFS_STAT): begin
            bus_rdata[B_BUSY] = busy;
            bus_rdata[B_DONE] = done_q;
            bus_rdata[B_ERR]  = err_q;
         end
         ADDR_W'(OFS_IEN): begin
            bus_rdata[B_DONE] = ie_done_q;
            bus_rdata[B_ERR]  = ie_err_q;
         end
         ADDR_W'(OFS_HITS): bus_rdata = 32'(hit_cnt);
         ADDR_W'(OFS_MISS): bus_rdata = 32'(miss_cnt);
         default:           bus_rdata = '0;
      endcase
   end

   assign cache_en   = en_q;
   assign assoc_mode = assoc_q;
   assign tag_clr_en = busy;
   assign irq        = (done_q && ie_done_q) || (err_q && ie_err_q);

   // R3: the request bit drops once busy has been seen
   assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !inv_q);
   // R2: associativity frozen while the cache is enabled
   assert_assoc_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(assoc_q));
   // R5: finished flag is up in the cycle busy falls
   assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q);
endmodule

// File: tb/test_icm_ctrl_unit.sv
module test_icm_ctrl_unit;
   localparam int LINES = 64;
   localparam int IDX_W = $clog2(LINES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic hit_stb = 1'b0, miss_stb = 1'b0, err_stb = 1'b0;
   logic cache_en, assoc_mode, tag_clr_en, irq;
   logic [IDX_W-1:0] tag_clr_idx;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   icm_ctrl_unit #(.LINES(LINES)) i_icm_ctrl_unit (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit_stb(hit_stb),
      .miss_stb(miss_stb), .err_stb(err_stb), .cache_en(cache_en),
      .assoc_mode(assoc_mode), .tag_clr_en(tag_clr_en),
      .tag_clr_idx(tag_clr_idx), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   function automatic logic [31:0] sat_add(input logic [31:0] v, input logic [31:0] top);
      return (v == top) ? v : v + 1;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] mh, mm;
      logic hen, men;
      void'($urandom(32'd2024));
      tick(2);
      rst_n = 1'b1;
      tick(1);

      // R1 reset values
      rd(8'h00, v); chk("R1 ctrl", v, 32'h4);
      rd(8'h04, v); chk("R1 status", v, 0);
      rd(8'h08, v); chk("R1 ien", v, 0);
      rd(8'h10, v); chk("R1 hits", v, 0);
      rd(8'h14, v); chk("R1 miss", v, 0);
      chk("R1 irq/clr", {irq, tag_clr_en}, 0);

      // R2 associativity lock
      wr(8'h00, 32'h1);  rd(8'h00, v); chk("R2 en set, assoc written 0", v, 32'h1);
      chk("R2 outputs", {cache_en, assoc_mode}, 2'b10);
      wr(8'h00, 32'h5);  rd(8'h00, v); chk("R2 assoc locked while enabled", v, 32'h1);
      wr(8'h00, 32'h4);  rd(8'h00, v); chk("R2 assoc locked on disabling write", v, 32'h0);
      wr(8'h00, 32'h4);  rd(8'h00, v); chk("R2 assoc written when disabled", v, 32'h4);

      // R3 writing 0 to the request bit does nothing
      tick(2);
      rd(8'h04, v); chk("R3 no sweep on zero write", v, 0);
      chk("R3 no clear strobe", tag_clr_en, 0);

      // R3/R4/R5 full sweep
      wr(8'h00, 32'h6);
      rd(8'h00, v); chk("R3 request reads 1", v, 32'h6);
      rd(8'h04, v); chk("R4 not busy yet", v, 0);
      for (int k = 0; k < LINES; k++) begin
         tick(1);
         chk("R4 clear strobe", tag_clr_en, 1);
         chk("R4 index", 32'(tag_clr_idx), k);
         rd(8'h04, v); chk("R4 busy", v, 32'h1);
         rd(8'h00, v);
         if (k == 0) chk("R3 request held first busy cycle", v, 32'h6);
         if (k == 1) chk("R3 request cleared", v, 32'h4);
      end
      tick(1);
      chk("R4 strobe ends after LINES", tag_clr_en, 0);
      rd(8'h04, v); chk("R5 finished set as busy falls", v, 32'h2);

      // R11 writes to read-only offsets ignored
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, v); chk("R11 status write ignored", v, 32'h2);

      // R5/R6/R7 error, clear, interrupt
      chk("R7 irq off when disabled", irq, 0);
      wr(8'h08, 32'h2); chk("R7 irq from finished", irq, 1);
      err_stb = 1'b1; tick(1); err_stb = 1'b0;
      rd(8'h04, v); chk("R5 error latched", v, 32'h6);
      wr(8'h08, 32'h4); chk("R7 irq from error", irq, 1);
      wr(8'h0C, 32'h4); chk("R7 irq off after error clear", irq, 0);
      rd(8'h04, v); chk("R6 error cleared", v, 32'h2);
      rd(8'h0C, v); chk("R6 clear reg reads 0", v, 0);
      wr(8'h08, 32'h2); chk("R7 irq finished again", irq, 1);
      wr(8'h0C, 32'h2); chk("R7 irq off after finished clear", irq, 0);
      rd(8'h04, v); chk("R6 finished cleared", v, 0);

      // R8/R9/R10 random counting rounds
      mh = 0; mm = 0;
      for (int r = 0; r < 4; r++) begin
         hen = (r == 0) ? 1'b1 : 1'($urandom);
         men = (r == 0) ? 1'b1 : 1'($urandom);
         if (r == 2) begin
            wr(8'h00, {12'h0, 2'b11, men, hen, 16'h4});
            mh = 0; mm = 0;
            rd(8'h10, v); chk("R10 hit reset", v, 0);
            rd(8'h14, v); chk("R10 miss reset", v, 0);
            rd(8'h00, v); chk("R10 reset bits read 0", v & 32'h000C_0000, 0);
         end else begin
            wr(8'h00, {14'h0, men, hen, 16'h4});
         end
         for (int i = 0; i < 300; i++) begin
            hit_stb = 1'($urandom); miss_stb = 1'($urandom);
            @(posedge clk);
            if (hit_stb && hen)  mh = sat_add(mh, 32'hFFFF_FFFF);
            if (miss_stb && men) mm = sat_add(mm, 32'h0000_FFFF);
            @(negedge clk);
         end
         hit_stb = 0; miss_stb = 0;
         rd(8'h10, v); chk("R8 hit count", v, mh);
         rd(8'h14, v); chk("R9 miss count", v, mm);
      end

      // R11 monitor writes ignored
      wr(8'h10, 32'h0); wr(8'h14, 32'h0);
      rd(8'h10, v); chk("R11 hit write ignored", v, mh);
      rd(8'h14, v); chk("R11 miss write ignored", v, mm);

      // R12 miss saturation, R9 upper bits zero
      wr(8'h00, 32'h0002_0004);
      miss_stb = 1'b1;
      tick(65540);
      miss_stb = 1'b0;
      rd(8'h14, v); chk("R12 miss saturates, R9 upper zero", v, 32'h0000_FFFF);
      tick(3);
      rd(8'h14, v); chk("R12 miss stays at top", v, 32'h0000_FFFF);
      wr(8'h00, 32'h000A_0004);
      rd(8'h14, v); chk("R10 miss reset after saturation", v, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule